// File: doc/BRIEF.md
# Threshold-Driven Receive Byte Buffer

This block is the receive side of a byte-oriented serial bus controller. It holds a small circular buffer and fills it in bursts. A burst asks the bus engine for one byte at a time, and it keeps going until the number of buffered bytes equals a programmed threshold or the buffer is full. When the threshold is reached, a sticky flag is raised. Software reads bytes out one at a time through a data-register read strobe. It clears the flag with a write-one to resume filling.

A sticky "final" control marks the byte that completes the threshold. That byte is requested with a negative acknowledge, which tells the remote end that the read is over. The control then clears itself. After each completed burst the block updates a data-ready bit and a buffer-full/empty bit for the surrounding register file. A clear command, a module disable and reset each empty the buffer.

Top module: `rxf_thresh_fifo`

## Requirements
- R1: After reset, `rx_ctl` reads 0x01 (threshold 1, final bit 0, interrupt-enable bit 0), `rx_sts` reads 0x00, and `data_ready`, `fifo_fe` and `bus_req` are all 0.
- R2: A burst starts on the edge after a trigger. A trigger is a `fill_start` pulse, a threshold-flag clear while `receiving`, or a pop of an empty buffer while `receiving`. `bus_req` then stays high until `bus_valid`, and the block requests bytes until the count equals the threshold (`rx_ctl[4:0]`) or reaches DEPTH.
- R3: Each byte is stored at (read pointer + count) mod DEPTH. Pops therefore return bytes in arrival order, including across the wrap of the storage.
- R4: When a burst reaches the threshold, the flag `rx_sts[6]` is set on the same edge that accepts the last byte. `rx_sts[4:0]` always holds the byte count, which ranges from 0 to DEPTH.
- R5: If the final bit `rx_ctl[5]` is set, `bus_nack` is 1 only while the byte that completes the threshold is being requested. The final bit clears on the edge on which the flag is set.
- R6: If the threshold exceeds DEPTH, the burst fills to DEPTH and stops. The flag stays clear, and `data_ready` and `fifo_fe` keep their values.
- R7: When a burst reaches the threshold with the buffer full, `data_ready` and `fifo_fe` are set. Otherwise `data_ready` becomes the inverse of the interrupt-enable bit `rx_ctl[6]`.
- R8: A `pop` pulse with a nonzero count loads the oldest byte into `rd_data` on the next edge and decrements the count.
- R9: A `pop` with a count of 0 starts a burst when `receiving` is high. When `receiving` is low it changes nothing.
- R10: An `sts_wr` write with bit 6 set clears the flag. A new burst starts only when `receiving` is high.
- R11: An `ctl_wr` write loads the threshold (bits 4:0) and the interrupt-enable bit (bit 6). Writing 1 to bit 5 sets the final bit, and writing 0 to bit 5 leaves it unchanged.
- R12: `clr_fifo` or a low `enable` empties the buffer, clears `fifo_fe` and abandons any burst on the next edge. While `enable` is low, no burst starts.
- R13: A trigger when the count already equals the threshold, or while a burst is running, requests nothing and changes nothing. A `pop` while a burst is running is likewise ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Module enable; low empties the buffer and blocks bursts |
| receiving | input | 1 | Controller is in a read transfer |
| fill_start | input | 1 | Pulse: start a burst (address phase of a read done) |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control write data: [4:0] threshold, [5] final, [6] interrupt enable |
| sts_wr | input | 1 | Write strobe for the status register |
| sts_wdata | input | 8 | Status write data: bit 6 = 1 clears the threshold flag |
| clr_fifo | input | 1 | Pulse: empty the buffer |
| pop | input | 1 | Data-register read strobe |
| rd_data | output | 8 | Last popped byte |
| rx_ctl | output | 8 | Control register value |
| rx_sts | output | 8 | Status: [4:0] count, [6] threshold flag |
| data_ready | output | 1 | Data-ready status bit |
| fifo_fe | output | 1 | Buffer full/empty status bit |
| bus_req | output | 1 | Request for one byte from the bus engine |
| bus_nack | output | 1 | Requested byte is to be negatively acknowledged |
| bus_valid | input | 1 | Bus engine delivers the requested byte |
| bus_data | input | 8 | Delivered byte |

## Verification
Every result is registered. A byte pop shows in `rd_data` and `rx_sts` one edge after the strobe, and `bus_req` rises one edge after a trigger. Burst completion (flag, `data_ready`, `fifo_fe`, final-bit clear) appears on the edge that accepts the last byte. The bench drives every input on the falling edge and samples on the falling edge after the relevant rising edge. For bursts it waits until `bus_req` is seen low before checking, which lands the check one half cycle after the completing edge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned REG_W        = 8;
  localparam int unsigned CNT_W        = 5;
  localparam int unsigned CTL_LAST_BIT = 5;
  localparam int unsigned CTL_IE_BIT   = 6;
  localparam int unsigned STS_FLAG_BIT = 6;

  typedef enum logic [0:0] {
    FS_IDLE = 1'b0,
    FS_FILL = 1'b1
  } fill_st_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = 8,
  parameter int unsigned CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [CW-1:0] count,
  output logic [DW-1:0] head
);
  // DEPTH is a power of two: the modulo is a truncation of the pointer sum.
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rptr_q, rptr_d, waddr;
  logic [CW-1:0] cnt_q, cnt_d;

  assign waddr = rptr_q + cnt_q[AW-1:0];

  always_comb begin
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (clear) begin
      rptr_d = '0;
      cnt_d  = '0;
    end else begin
      if (rd_en) rptr_d = rptr_q + AW'(1);
      case ({wr_en, rd_en})
        2'b10:   cnt_d = cnt_q + CW'(1);
        2'b01:   cnt_d = cnt_q - CW'(1);
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // Data array carries no reset; entries are only read below the count.
  always_ff @(posedge clk) begin
    if (wr_en && !clear) mem[waddr] <= wr_data;
  end

  assign count = cnt_q;
  assign head  = mem[rptr_q];
endmodule

// File: rtl/rxf_fill_fsm.sv
module rxf_fill_fsm
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          clear,
  input  logic          go,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] thr,
  input  logic          last,
  input  logic          bus_valid,
  output logic          bus_req,
  output logic          bus_nack,
  output logic          accept,
  output logic          hit,
  output logic          full,
  output logic          busy
);
  localparam logic [CW:0] DEPTH_X = (CW+1)'(DEPTH);

  fill_st_e    st_q, st_d;
  logic [CW:0] cnt_x, thr_x, nxt_x;
  logic        want, more, finish;

  assign cnt_x = {1'b0, count};
  assign thr_x = {1'b0, thr};
  assign nxt_x = cnt_x + (CW+1)'(1);
  assign want  = (cnt_x < thr_x) && (cnt_x < DEPTH_X);
  assign more  = (nxt_x < thr_x) && (nxt_x < DEPTH_X);
  assign busy  = (st_q == FS_FILL);

  always_comb begin
    st_d   = st_q;
    finish = 1'b0;
    case (st_q)
      FS_IDLE: begin
        if (enable && !clear && go && want) st_d = FS_FILL;
      end
      FS_FILL: begin
        if (!enable || clear) begin
          st_d = FS_IDLE;
        end else if (bus_valid && !more) begin
          st_d   = FS_IDLE;
          finish = 1'b1;
        end
      end
      default: st_d = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= FS_IDLE;
    else        st_q <= st_d;
  end

  assign accept   = busy && enable && !clear && bus_valid;
  assign hit      = finish && (nxt_x == thr_x);
  assign full     = finish && (nxt_x == DEPTH_X);
  assign bus_req  = busy;
  assign bus_nack = busy && last && (nxt_x == thr_x);
endmodule

// File: rtl/rxf_regs.sv
module rxf_regs
  import rxf_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             ctl_wr,
  input  logic [REG_W-1:0] ctl_wdata,
  input  logic             sts_wr,
  input  logic [REG_W-1:0] sts_wdata,
  input  logic             hit,
  input  logic             full,
  input  logic             pop_ok,
  input  logic [REG_W-1:0] head,
  output logic [CW-1:0]    thr,
  output logic             ie,
  output logic             last,
  output logic             flag,
  output logic             data_ready,
  output logic             fe,
  output logic [REG_W-1:0] rd_data
);
  logic [CW-1:0]    thr_q, thr_d;
  logic             ie_q, ie_d, last_q, last_d, flag_q, flag_d;
  logic             dr_q, dr_d, fe_q, fe_d;
  logic [REG_W-1:0] rd_q, rd_d;

  always_comb begin
    thr_d  = thr_q;
    ie_d   = ie_q;
    last_d = last_q;
    flag_d = flag_q;
    dr_d   = dr_q;
    fe_d   = fe_q;
    rd_d   = rd_q;
    // Completion of a burst that met its threshold.
    if (hit) begin
      flag_d = 1'b1;
      last_d = 1'b0;
      dr_d   = full ? 1'b1 : !ie_q;
      if (full) fe_d = 1'b1;
    end
    // Software writes; a set of the final bit wins over the self-clear.
    if (ctl_wr) begin
      thr_d = ctl_wdata[CW-1:0];
      ie_d  = ctl_wdata[CTL_IE_BIT];
      if (ctl_wdata[CTL_LAST_BIT]) last_d = 1'b1;
    end
    if (sts_wr && sts_wdata[STS_FLAG_BIT] && !hit) flag_d = 1'b0;
    if (clear) fe_d = 1'b0;
    if (pop_ok) rd_d = head;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= CW'(1);
      ie_q   <= 1'b0;
      last_q <= 1'b0;
      flag_q <= 1'b0;
      dr_q   <= 1'b0;
      fe_q   <= 1'b0;
      rd_q   <= '0;
    end else begin
      thr_q  <= thr_d;
      ie_q   <= ie_d;
      last_q <= last_d;
      flag_q <= flag_d;
      dr_q   <= dr_d;
      fe_q   <= fe_d;
      rd_q   <= rd_d;
    end
  end

  assign thr        = thr_q;
  assign ie         = ie_q;
  assign last       = last_q;
  assign flag       = flag_q;
  assign data_ready = dr_q;
  assign fe         = fe_q;
  assign rd_data    = rd_q;
endmodule

// File: rtl/rxf_thresh_fifo.sv
module rxf_thresh_fifo
  import rxf_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       receiving,
  input  logic       fill_start,
  input  logic       ctl_wr,
  input  logic [7:0] ctl_wdata,
  input  logic       sts_wr,
  input  logic [7:0] sts_wdata,
  input  logic       clr_fifo,
  input  logic       pop,
  output logic [7:0] rd_data,
  output logic [7:0] rx_ctl,
  output logic [7:0] rx_sts,
  output logic       data_ready,
  output logic       fifo_fe,
  output logic       bus_req,
  output logic       bus_nack,
  input  logic       bus_valid,
  input  logic [7:0] bus_data
);
  localparam int unsigned CW = CNT_W;

  logic          clear_any, busy, accept, hit, full, go, pop_ok, empty;
  logic [CW-1:0] count, thr;
  logic          ie, last, flag;
  logic [7:0]    head;

  assign clear_any = clr_fifo || !enable;
  assign empty     = (count == '0);
  assign pop_ok    = pop && !busy && !empty && !clear_any;
  assign go        = fill_start
                   || (sts_wr && sts_wdata[STS_FLAG_BIT] && receiving)
                   || (pop && empty && receiving);

  rxf_store #(.DEPTH(DEPTH), .DW(REG_W), .CW(CW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear_any),
    .wr_en   (accept),
    .wr_data (bus_data),
    .rd_en   (pop_ok),
    .count   (count),
    .head    (head)
  );

  rxf_fill_fsm #(.DEPTH(DEPTH), .CW(CW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .clear     (clr_fifo),
    .go        (go),
    .count     (count),
    .thr       (thr),
    .last      (last),
    .bus_valid (bus_valid),
    .bus_req   (bus_req),
    .bus_nack  (bus_nack),
    .accept    (accept),
    .hit       (hit),
    .full      (full),
    .busy      (busy)
  );

  rxf_regs #(.CW(CW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear_any),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .sts_wr     (sts_wr),
    .sts_wdata  (sts_wdata),
    .hit        (hit),
    .full       (full),
    .pop_ok     (pop_ok),
    .head       (head),
    .thr        (thr),
    .ie         (ie),
    .last       (last),
    .flag       (flag),
    .data_ready (data_ready),
    .fe         (fifo_fe),
    .rd_data    (rd_data)
  );

  assign rx_ctl = {1'b0, ie, last, thr};
  assign rx_sts = {1'b0, flag, 1'b0, count};
endmodule

// File: rtl/rxf_thresh_fifo_chk.sv
module rxf_thresh_fifo_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       clr_fifo,
  input logic       ctl_wr,
  input logic [7:0] rx_ctl,
  input logic [7:0] rx_sts,
  input logic       data_ready,
  input logic       fifo_fe,
  input logic       bus_req,
  input logic       bus_nack,
  input logic       bus_valid
);
  // R4: the count never exceeds the buffer depth
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rx_sts[4:0]) <= int'(DEPTH));

  // R2: a byte request is held until the byte arrives
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_valid && enable && !clr_fifo) |=> bus_req);

  // R4: the flag rises only with the count at the threshold
  p_flag_at_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_sts[6]) && !$past(ctl_wr)) |-> (rx_sts[4:0] == rx_ctl[4:0]));

  // R5: negative acknowledge only on the final requested byte
  p_nack_final_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_nack) |-> (rx_ctl[5] && (({1'b0, rx_sts[4:0]} + 6'd1) == {1'b0, rx_ctl[4:0]})));

  // R5: the final bit clears itself when the flag is raised
  p_last_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rx_sts[6]) && $past(rx_ctl[5]) && !$past(ctl_wr)) |-> !rx_ctl[5]);

  // R7: full/empty rises only together with data-ready
  p_full_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fifo_fe) |-> data_ready);

  // R12: clear or disable empties the buffer and ends any burst
  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fifo || !enable) |=> ((rx_sts[4:0] == 5'd0) && !fifo_fe && !bus_req));
endmodule

bind rxf_thresh_fifo rxf_thresh_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .clr_fifo   (clr_fifo),
  .ctl_wr     (ctl_wr),
  .rx_ctl     (rx_ctl),
  .rx_sts     (rx_sts),
  .data_ready (data_ready),
  .fifo_fe    (fifo_fe),
  .bus_req    (bus_req),
  .bus_nack   (bus_nack),
  .bus_valid  (bus_valid)
);

// File: tb/rxf_thresh_fifo_tb.sv
module rxf_thresh_fifo_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic enable, receiving, fill_start, ctl_wr, sts_wr, clr_fifo, pop;
  logic [7:0] ctl_wdata, sts_wdata, rd_data, rx_ctl, rx_sts, bus_data;
  logic data_ready, fifo_fe, bus_req, bus_nack, bus_valid;

  int n_checks = 0;
  int n_errors = 0;
  int req_cycles = 0;
  int cycles = 0;
  bit resp_en = 1'b1;
  int gap = 0;
  logic [7:0] exp_q[$];
  bit         nack_q[$];
  bit         exp_dr;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxf_thresh_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .receiving(receiving),
    .fill_start(fill_start), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .sts_wr(sts_wr), .sts_wdata(sts_wdata), .clr_fifo(clr_fifo), .pop(pop),
    .rd_data(rd_data), .rx_ctl(rx_ctl), .rx_sts(rx_sts),
    .data_ready(data_ready), .fifo_fe(fifo_fe), .bus_req(bus_req),
    .bus_nack(bus_nack), .bus_valid(bus_valid), .bus_data(bus_data)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (bus_req) req_cycles <= req_cycles + 1;
  end

  // Bus engine model: serves requests after a random gap, one-cycle pulses.
  always @(negedge clk) begin
    if (bus_valid) begin
      bus_valid = 1'b0;
    end else if (bus_req && resp_en) begin
      if (gap != 0) gap = gap - 1;
      else begin
        bus_valid = 1'b1;
        bus_data  = 8'($urandom);
        exp_q.push_back(bus_data);
        nack_q.push_back(bus_nack);
        gap = $urandom_range(0, 2);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int exp_sts(input int thr);
    int c;
    c = (thr < DEPTH) ? thr : DEPTH;
    return ((thr <= DEPTH) ? 32'h40 : 0) | c;
  endfunction

  task automatic wait_burst();
    int n = 0;
    while (bus_req && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_sts(input logic [7:0] v);
    @(negedge clk); sts_wr = 1'b1; sts_wdata = v;
    @(negedge clk); sts_wr = 1'b0;
    wait_burst();
  endtask

  task automatic start_fill();
    @(negedge clk); fill_start = 1'b1;
    @(negedge clk); fill_start = 1'b0;
    wait_burst();
  endtask

  task automatic pop_chk(input string req);
    logic [7:0] e;
    @(negedge clk); pop = 1'b1;
    @(negedge clk); pop = 1'b0;
    e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
    check(req, rd_data, e);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr_fifo = 1'b1;
    @(negedge clk); clr_fifo = 1'b0;
    exp_q.delete();
  endtask

  initial begin
    int rc;
    void'($urandom(32'd4242));
    rst_n = 1'b0; enable = 1'b0; receiving = 1'b0; fill_start = 1'b0;
    ctl_wr = 1'b0; sts_wr = 1'b0; clr_fifo = 1'b0; pop = 1'b0;
    ctl_wdata = '0; sts_wdata = '0; bus_valid = 1'b0; bus_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 ctl", rx_ctl, 8'h01);
    check("R1 sts", rx_sts, 8'h00);
    check("R1 ready/fe/req", {data_ready, fifo_fe, bus_req}, 3'b000);

    enable = 1'b1; receiving = 1'b1;
    wr_ctl(8'h04);
    check("R11 ctl load", rx_ctl, 8'h04);
    start_fill();
    check("R2 R4 burst to threshold", rx_sts, 8'h44);
    check("R2 request dropped", bus_req, 0);
    check("R7 ready with ie off", data_ready, 1);
    check("R7 fe not full", fifo_fe, 0);
    check("R5 no nack without final", nack_q.size() == 4 && nack_q.sum() == 0, 1);

    // R13 trigger at threshold requests nothing
    rc = req_cycles;
    start_fill(); repeat (3) @(negedge clk);
    check("R13 no request at threshold", req_cycles - rc, 0);
    check("R13 status unchanged", rx_sts, 8'h44);

    pop_chk("R8 pop data 0"); pop_chk("R8 pop data 1");
    check("R8 count after pops", rx_sts, 8'h42);

    wr_ctl(8'h66); wr_ctl(8'h06);
    check("R11 final bit sticky on zero write", rx_ctl, 8'h26);
    wr_ctl(8'h66);
    nack_q.delete();
    wr_sts(8'h40);
    check("R10 R4 refill after flag clear", rx_sts, 8'h46);
    check("R5 nack on final byte only",
          (nack_q.size() == 4) && nack_q[3] && !nack_q[0] && !nack_q[1] && !nack_q[2], 1);
    check("R5 final bit self-cleared", rx_ctl, 8'h46);
    check("R7 ready follows ie on", data_ready, 0);
    for (int i = 0; i < 6; i++) pop_chk("R8 R3 drain");
    check("R8 empty after drain", rx_sts, 8'h40);

    // R9 pop on empty while not receiving does nothing
    receiving = 1'b0; rc = req_cycles;
    @(negedge clk); pop = 1'b1; @(negedge clk); pop = 1'b0; repeat (3) @(negedge clk);
    check("R9 idle pop no request", req_cycles - rc, 0);
    check("R9 idle pop status", rx_sts, 8'h40);

    wr_ctl(8'h03);
    wr_sts(8'h40);
    check("R10 flag clear without receiving", rx_sts, 8'h00);
    check("R10 no request when not receiving", req_cycles - rc, 0);
    receiving = 1'b1;
    @(negedge clk); pop = 1'b1; @(negedge clk); pop = 1'b0;
    wait_burst();
    check("R9 empty pop starts burst", rx_sts, 8'h43);

    // Full buffer, wrapped pointer
    wr_ctl(8'h50);
    wr_sts(8'h40);
    check("R4 full threshold", rx_sts, 8'h50);
    check("R7 full forces ready", data_ready, 1);
    check("R7 full sets fe", fifo_fe, 1);
    for (int i = 0; i < DEPTH; i++) pop_chk("R3 wrap order");

    pulse_clr();
    check("R12 clear drops fe", fifo_fe, 0);
    wr_ctl(8'h54);
    wr_sts(8'h40);
    check("R6 stops at depth without flag", rx_sts, 8'h10);
    check("R6 ready unchanged", data_ready, 1);
    check("R6 fe unchanged", fifo_fe, 0);
    exp_dr = 1'b1;

    pulse_clr();
    check("R12 clear empties", rx_sts, 8'h00);
    resp_en = 1'b0;
    wr_ctl(8'h05);
    @(negedge clk); fill_start = 1'b1; @(negedge clk); fill_start = 1'b0;
    check("R2 request raised", bus_req, 1);
    @(negedge clk); pop = 1'b1; fill_start = 1'b1; @(negedge clk); pop = 1'b0; fill_start = 1'b0;
    check("R13 pop during burst ignored", {bus_req, rx_sts}, {1'b1, 8'h00});
    @(negedge clk); enable = 1'b0; @(negedge clk);
    check("R12 disable abandons burst", {bus_req, rx_sts}, {1'b0, 8'h00});
    rc = req_cycles;
    @(negedge clk); fill_start = 1'b1; @(negedge clk); fill_start = 1'b0; repeat (2) @(negedge clk);
    check("R12 no burst while disabled", req_cycles - rc, 0);
    enable = 1'b1; resp_en = 1'b1;

    // Random bursts and partial drains
    for (int it = 0; it < 40; it++) begin
      int thr, ie, k, c;
      pulse_clr();
      receiving = 1'b0;
      wr_sts(8'h40);
      thr = $urandom_range(1, 20);
      ie  = $urandom_range(0, 1);
      wr_ctl(8'((ie << 6) | thr));
      receiving = 1'b1;
      start_fill();
      check("R2 R4 random burst", rx_sts, exp_sts(thr));
      if (thr <= DEPTH) exp_dr = (thr == DEPTH) ? 1'b1 : !ie[0];
      check("R7 R6 random ready", data_ready, exp_dr);
      check("R7 random fe", fifo_fe, (thr == DEPTH) ? 1 : 0);
      c = (thr < DEPTH) ? thr : DEPTH;
      k = $urandom_range(1, c);
      for (int j = 0; j < k; j++) pop_chk("R8 R3 random pop");
      check("R8 random count", rx_sts[4:0], c - k);
    end

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cycles);
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule